// File: doc/BRIEF.md
# Write-Back Data Cache with Invalidate-on-Write

This block is a small set-associative data cache that sits between one processor and main memory in a multiprocessor system. Every line holds 64 bytes and three flags: valid, shared (another cache may hold a copy) and dirty (the cached copy differs from memory). Processor writes touch only the cached copy. Memory sees a line only when a dirty line is evicted or when another cache snoops it away.

Lines fetched from memory are installed as shared and clean. The first processor write to a shared line does three things: it commits the bytes, it moves the line to private and dirty, and it raises an invalidate request carrying the line address so that the other caches drop their copies. The processor stays stalled until that request is acknowledged. Later writes to the same line go through without any broadcast.

Invalidate requests arriving from other caches clear the matching line, and a dirty line is written back first. On a miss, the victim is chosen in this order: an invalid way if one exists, otherwise a way picked by a free-running LFSR.

Top module: `wbc_cache`

## Requirements
- R1: A read hit raises `cpuAck` in the same cycle the request is presented, with the addressed 64-bit word on `cpuRdata`, and issues no memory request.
- R2: A write hit changes only the enabled bytes of the selected word and issues no memory write. Byte b of the word corresponds to `cpuReqWdata[8b+7:8b]` and `cpuReqByteEn[b]`. The word is selected by address bits [5:3].
- R3: A read miss fetches the whole line from memory, returns the requested word, and installs the line as shared and clean.
- R4: The first write to a shared line commits the bytes, marks the line private and dirty, and raises `invReqValid` with the line address (address bits 31:6). `invReqValid` and the address stay steady until `invAck`. The processor is acknowledged only in the `invAck` cycle.
- R5: A write to a private, dirty line raises no invalidate and is acknowledged in the cycle it is presented.
- R6: A write miss refills the line, applies the write, and then raises one invalidate request for that line.
- R7: A miss fills an invalid way of the set before it replaces any valid way. The set is address bits [7:6] with the default four sets.
- R8: A dirty victim is written back as a full line to its own line address, and the write is accepted before the refill read is issued.
- R9: A clean victim is replaced without any memory write.
- R10: A snoop that hits a clean line invalidates it, raises `snpAck`, and causes no memory write.
- R11: A snoop that hits a dirty line writes the line back, then invalidates it. `snpAck` is raised in the cycle the write-back is accepted.
- R12: A snoop that misses is acknowledged and leaves every resident line in place.
- R13: After reset all lines are invalid and `cpuAck`, `memReqValid`, `invReqValid` and `snpAck` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReqValid | input | 1 | Processor request, held until `cpuAck` |
| cpuReqWrite | input | 1 | 1 = write, 0 = read |
| cpuReqAddr | input | 32 | Byte address; bits [2:0] are ignored |
| cpuReqWdata | input | 64 | Write data word |
| cpuReqByteEn | input | 8 | Byte enables for writes |
| cpuAck | output | 1 | Request complete in this cycle |
| cpuRdata | output | 64 | Read data, valid with `cpuAck` on reads |
| memReqValid | output | 1 | Memory request, held until `memReqReady` |
| memReqWrite | output | 1 | 1 = line write-back, 0 = line fetch |
| memReqAddr | output | 26 | Line address |
| memReqData | output | 512 | Line data for write-backs |
| memReqReady | input | 1 | Memory accepts the request |
| memRespValid | input | 1 | Fetched line is present on `memRespData` |
| memRespData | input | 512 | Fetched line data |
| invReqValid | output | 1 | Invalidate broadcast to other caches |
| invReqAddr | output | 26 | Line address of the broadcast |
| invAck | input | 1 | Broadcast acknowledged |
| snpValid | input | 1 | Incoming invalidate, held until `snpAck` |
| snpAddr | input | 26 | Line address of the incoming invalidate |
| snpAck | output | 1 | Incoming invalidate complete |

## Verification
Hits to read and hits to private lines for write are answered combinationally, in the cycle they are presented. The bench drives a request just after a falling edge, samples `cpuAck` one nanosecond later, and expects a wait of zero cycles. A write to a shared line stays unanswered until the modelled acknowledge arrives two cycles into the broadcast, so the bench expects a stall of at least two cycles and reads the broadcast address once the request has closed.

Misses take one cycle per memory request plus the modelled fetch latency. The bench therefore never checks their latency. Instead, its memory model counts write-backs and fetches, records the write-back count at the moment each fetch is issued, and keeps the written-back lines, so ordering and data are checked once the request has completed.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  localparam int LINE_BYTES  = 64;
  localparam int LINE_BITS   = LINE_BYTES * 8;
  localparam int WORD_BYTES  = 8;
  localparam int WORD_BITS   = WORD_BYTES * 8;
  localparam int LINE_OFF_W  = $clog2(LINE_BYTES);
  localparam int WORD_OFF_W  = $clog2(WORD_BYTES);
  localparam int WSEL_W      = LINE_OFF_W - WORD_OFF_W;
  localparam int LFSR_W      = 8;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8;

  typedef struct packed {
    logic latchVictim;
    logic refillWe;
    logic cpuWrite;
    logic snpClear;
    logic memSrcSnoop;
    logic memSrcVictim;
  } dpCtrl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_INV_WAIT,
    ST_SNP_WB
  } ctrlState_t;
endpackage

// File: rtl/wbc_datapath.sv
module wbc_datapath import wbc_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 4,
  parameter int WAYS   = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpCtrl_t                      strb,
  input  logic [ADDR_W-1:0]            cpuAddr,
  input  logic [WORD_BITS-1:0]         cpuWdata,
  input  logic [WORD_BYTES-1:0]        cpuByteEn,
  input  logic [ADDR_W-LINE_OFF_W-1:0] snpLineAddr,
  input  logic [LINE_BITS-1:0]         memRespData,
  output logic                         cpuHit,
  output logic                         cpuHitShared,
  output logic                         victimDirty,
  output logic                         snpHit,
  output logic                         snpHitDirty,
  output logic [WORD_BITS-1:0]         cpuRdata,
  output logic [ADDR_W-LINE_OFF_W-1:0] cpuLineAddr,
  output logic [ADDR_W-LINE_OFF_W-1:0] memReqAddr,
  output logic [LINE_BITS-1:0]         memReqData
);
  localparam int IDX_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int LADDR_W = ADDR_W - LINE_OFF_W;
  localparam int TAG_W   = LADDR_W - IDX_W;

  logic [TAG_W-1:0]     tagArr  [SETS][WAYS];
  logic [LINE_BITS-1:0] dataArr [SETS][WAYS];
  logic [WAYS-1:0]      validArr [SETS];
  logic [WAYS-1:0]      sharedArr[SETS];
  logic [WAYS-1:0]      dirtyArr [SETS];

  logic [IDX_W-1:0]  cpuIdx, snpIdx;
  logic [TAG_W-1:0]  cpuTag, snpTag;
  logic [WSEL_W-1:0] wordSel;
  logic [WORD_OFF_W-1:0] unusedLowBits;
  logic [WAYS-1:0]   cpuHitVec, snpHitVec;
  logic [WAY_W-1:0]  cpuWay, snpWay, freeWay, pickWay, vicWayQ;
  logic              freeFound;
  logic [LFSR_W-1:0] lfsrQ;
  logic [LADDR_W-1:0] victimLineAddr;

  assign cpuIdx        = cpuAddr[LINE_OFF_W +: IDX_W];
  assign cpuTag        = cpuAddr[ADDR_W-1 -: TAG_W];
  assign wordSel       = cpuAddr[WORD_OFF_W +: WSEL_W];
  assign unusedLowBits = cpuAddr[WORD_OFF_W-1:0];
  assign snpIdx        = snpLineAddr[IDX_W-1:0];
  assign snpTag        = snpLineAddr[LADDR_W-1 -: TAG_W];
  assign cpuLineAddr   = cpuAddr[ADDR_W-1:LINE_OFF_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign cpuHitVec[w] = validArr[cpuIdx][w] && (tagArr[cpuIdx][w] == cpuTag);
    assign snpHitVec[w] = validArr[snpIdx][w] && (tagArr[snpIdx][w] == snpTag);
  end

  always_comb begin
    cpuWay    = '0;
    snpWay    = '0;
    freeWay   = '0;
    freeFound = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (cpuHitVec[w]) cpuWay = WAY_W'(w);
      if (snpHitVec[w]) snpWay = WAY_W'(w);
      if (!freeFound && !validArr[cpuIdx][w]) begin
        freeFound = 1'b1;
        freeWay   = WAY_W'(w);
      end
    end
  end

  assign pickWay      = freeFound ? freeWay : lfsrQ[WAY_W-1:0];
  assign victimDirty  = validArr[cpuIdx][pickWay] && dirtyArr[cpuIdx][pickWay];
  assign cpuHit       = |cpuHitVec;
  assign cpuHitShared = sharedArr[cpuIdx][cpuWay];
  assign snpHit       = |snpHitVec;
  assign snpHitDirty  = dirtyArr[snpIdx][snpWay];
  assign cpuRdata     = dataArr[cpuIdx][cpuWay][int'(wordSel)*WORD_BITS +: WORD_BITS];

  assign victimLineAddr = {tagArr[cpuIdx][vicWayQ], cpuIdx};
  assign memReqAddr = strb.memSrcSnoop  ? snpLineAddr :
                      strb.memSrcVictim ? victimLineAddr : cpuLineAddr;
  assign memReqData = strb.memSrcSnoop ? dataArr[snpIdx][snpWay] : dataArr[cpuIdx][vicWayQ];

  // line flags, victim latch and replacement LFSR
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validArr[s]  <= '0;
        sharedArr[s] <= '0;
        dirtyArr[s]  <= '0;
      end
      vicWayQ <= '0;
      lfsrQ   <= LFSR_W'(1);
    end else begin
      lfsrQ <= {lfsrQ[LFSR_W-2:0], ^(lfsrQ & LFSR_TAPS)};
      if (strb.latchVictim) vicWayQ <= pickWay;
      if (strb.refillWe) begin
        validArr[cpuIdx][vicWayQ]  <= 1'b1;
        sharedArr[cpuIdx][vicWayQ] <= 1'b1;
        dirtyArr[cpuIdx][vicWayQ]  <= 1'b0;
      end
      if (strb.cpuWrite) begin
        sharedArr[cpuIdx][cpuWay] <= 1'b0;
        dirtyArr[cpuIdx][cpuWay]  <= 1'b1;
      end
      if (strb.snpClear) begin
        validArr[snpIdx][snpWay]  <= 1'b0;
        sharedArr[snpIdx][snpWay] <= 1'b0;
        dirtyArr[snpIdx][snpWay]  <= 1'b0;
      end
    end
  end

  // tag and data storage, no reset
  always_ff @(posedge clk) begin
    if (strb.refillWe) begin
      dataArr[cpuIdx][vicWayQ] <= memRespData;
      tagArr[cpuIdx][vicWayQ]  <= cpuTag;
    end
    if (strb.cpuWrite) begin
      for (int b = 0; b < WORD_BYTES; b++) begin
        if (cpuByteEn[b])
          dataArr[cpuIdx][cpuWay][int'(wordSel)*WORD_BITS + b*8 +: 8] <= cpuWdata[b*8 +: 8];
      end
    end
  end

  // R3
  refill_shared_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.refillWe |=> cpuHit && cpuHitShared);

  for (genvar s = 0; s < SETS; s++) begin : g_setChk
    // R4
    excl_state_chk: assert property (@(posedge clk) disable iff (!rstN)
      (sharedArr[s] & dirtyArr[s]) == '0);
  end
endmodule

// File: rtl/wbc_control.sv
module wbc_control import wbc_pkg::*; (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cpuReqValid,
  input  logic    cpuReqWrite,
  input  logic    cpuHit,
  input  logic    cpuHitShared,
  input  logic    victimDirty,
  input  logic    snpValid,
  input  logic    snpHit,
  input  logic    snpHitDirty,
  input  logic    memReqReady,
  input  logic    memRespValid,
  input  logic    invAck,
  output dpCtrl_t strb,
  output logic    cpuAck,
  output logic    memReqValid,
  output logic    memReqWrite,
  output logic    invReqValid,
  output logic    snpAck
);
  ctrlState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    strb        = '0;
    cpuAck      = 1'b0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    invReqValid = 1'b0;
    snpAck      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (snpValid) begin
          if (!snpHit) snpAck = 1'b1;
          else if (snpHitDirty) nextState = ST_SNP_WB;
          else begin
            strb.snpClear = 1'b1;
            snpAck        = 1'b1;
          end
        end else if (cpuReqValid) begin
          if (cpuHit) begin
            if (!cpuReqWrite) cpuAck = 1'b1;
            else begin
              strb.cpuWrite = 1'b1;
              if (cpuHitShared) nextState = ST_INV_WAIT;
              else              cpuAck    = 1'b1;
            end
          end else begin
            strb.latchVictim = 1'b1;
            nextState = victimDirty ? ST_WB : ST_FILL_REQ;
          end
        end
      end
      ST_WB: begin
        memReqValid       = 1'b1;
        memReqWrite       = 1'b1;
        strb.memSrcVictim = 1'b1;
        if (memReqReady) nextState = ST_FILL_REQ;
      end
      ST_FILL_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) nextState = ST_FILL_WAIT;
      end
      ST_FILL_WAIT: begin
        if (memRespValid) begin
          strb.refillWe = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      ST_INV_WAIT: begin
        invReqValid = 1'b1;
        if (invAck) begin
          cpuAck    = 1'b1;
          nextState = ST_IDLE;
        end
      end
      ST_SNP_WB: begin
        memReqValid      = 1'b1;
        memReqWrite      = 1'b1;
        strb.memSrcSnoop = 1'b1;
        if (memReqReady) begin
          strb.snpClear = 1'b1;
          snpAck        = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R4
  inv_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    invReqValid && !invAck |=> invReqValid);
  // R4
  inv_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    invReqValid && !invAck |-> !cpuAck);
  // R1
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuAck |-> !memReqValid);
  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqWrite));
  // R8
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqWrite && memReqReady && !snpAck |=> memReqValid && !memReqWrite);
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache import wbc_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 4,
  parameter int WAYS   = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cpuReqValid,
  input  logic                         cpuReqWrite,
  input  logic [ADDR_W-1:0]            cpuReqAddr,
  input  logic [WORD_BITS-1:0]         cpuReqWdata,
  input  logic [WORD_BYTES-1:0]        cpuReqByteEn,
  output logic                         cpuAck,
  output logic [WORD_BITS-1:0]         cpuRdata,
  output logic                         memReqValid,
  output logic                         memReqWrite,
  output logic [ADDR_W-LINE_OFF_W-1:0] memReqAddr,
  output logic [LINE_BITS-1:0]         memReqData,
  input  logic                         memReqReady,
  input  logic                         memRespValid,
  input  logic [LINE_BITS-1:0]         memRespData,
  output logic                         invReqValid,
  output logic [ADDR_W-LINE_OFF_W-1:0] invReqAddr,
  input  logic                         invAck,
  input  logic                         snpValid,
  input  logic [ADDR_W-LINE_OFF_W-1:0] snpAddr,
  output logic                         snpAck
);
  dpCtrl_t strb;
  logic cpuHit, cpuHitShared, victimDirty, snpHit, snpHitDirty;

  wbc_datapath #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .cpuAddr      (cpuReqAddr),
    .cpuWdata     (cpuReqWdata),
    .cpuByteEn    (cpuReqByteEn),
    .snpLineAddr  (snpAddr),
    .memRespData  (memRespData),
    .cpuHit       (cpuHit),
    .cpuHitShared (cpuHitShared),
    .victimDirty  (victimDirty),
    .snpHit       (snpHit),
    .snpHitDirty  (snpHitDirty),
    .cpuRdata     (cpuRdata),
    .cpuLineAddr  (invReqAddr),
    .memReqAddr   (memReqAddr),
    .memReqData   (memReqData)
  );

  wbc_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .cpuReqValid  (cpuReqValid),
    .cpuReqWrite  (cpuReqWrite),
    .cpuHit       (cpuHit),
    .cpuHitShared (cpuHitShared),
    .victimDirty  (victimDirty),
    .snpValid     (snpValid),
    .snpHit       (snpHit),
    .snpHitDirty  (snpHitDirty),
    .memReqReady  (memReqReady),
    .memRespValid (memRespValid),
    .invAck       (invAck),
    .strb         (strb),
    .cpuAck       (cpuAck),
    .memReqValid  (memReqValid),
    .memReqWrite  (memReqWrite),
    .invReqValid  (invReqValid),
    .snpAck       (snpAck)
  );

  // R4
  inv_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    invReqValid && !invAck |=> $stable(invReqAddr));
  // R13
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> !cpuAck && !memReqValid && !invReqValid);
endmodule

// File: tb/wbc_cache_bench.sv
`timescale 1ns/1ps
module wbc_cache_bench;
  localparam int ADDR_W  = 32;
  localparam int LADDR_W = 26;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReqValid = 1'b0, cpuReqWrite = 1'b0;
  logic [ADDR_W-1:0] cpuReqAddr = '0;
  logic [63:0] cpuReqWdata = '0;
  logic [7:0]  cpuReqByteEn = '0;
  logic cpuAck;
  logic [63:0] cpuRdata;
  logic memReqValid, memReqWrite;
  logic [LADDR_W-1:0] memReqAddr;
  logic [511:0] memReqData;
  logic memReqReady = 1'b1;
  logic memRespValid = 1'b0;
  logic [511:0] memRespData = '0;
  logic invReqValid;
  logic [LADDR_W-1:0] invReqAddr;
  logic invAck = 1'b0;
  logic snpValid = 1'b0;
  logic [LADDR_W-1:0] snpAddr = '0;
  logic snpAck;

  int checks = 0, errors = 0;
  int fillCount = 0, wbCount = 0, invCount = 0, wbAtFill = 0;
  int lastWb = -1, lastInv = -1;
  int respDelay = 0, pendLine = 0, invWait = 0;
  bit done = 1'b0;
  logic [511:0] lineMem [64];

  always #4 clk = ~clk;

  wbc_cache u_wbc_cache (
    .clk(clk), .rstN(rstN),
    .cpuReqValid(cpuReqValid), .cpuReqWrite(cpuReqWrite), .cpuReqAddr(cpuReqAddr),
    .cpuReqWdata(cpuReqWdata), .cpuReqByteEn(cpuReqByteEn),
    .cpuAck(cpuAck), .cpuRdata(cpuRdata),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .memReqData(memReqData), .memReqReady(memReqReady),
    .memRespValid(memRespValid), .memRespData(memRespData),
    .invReqValid(invReqValid), .invReqAddr(invReqAddr), .invAck(invAck),
    .snpValid(snpValid), .snpAddr(snpAddr), .snpAck(snpAck)
  );

  function automatic logic [63:0] pat(int line, int word);
    return {16'hBEEF, line[15:0], 24'h0, word[7:0]};
  endfunction

  function automatic logic [63:0] merge(logic [63:0] oldW, logic [63:0] newW, logic [7:0] be);
    logic [63:0] r = oldW;
    for (int b = 0; b < 8; b++) if (be[b]) r[b*8 +: 8] = newW[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [63:0] memWord(int line, int word);
    return lineMem[line][word*64 +: 64];
  endfunction

  // memory and coherence-fabric model
  always @(posedge clk) begin
    invAck <= 1'b0;
    memRespValid <= 1'b0;
    if (invReqValid && !invAck) begin
      invWait++;
      if (invWait >= 2) begin
        invAck <= 1'b1;
        invCount++;
        lastInv = int'(invReqAddr);
        invWait = 0;
      end
    end
    if (respDelay > 0) begin
      respDelay--;
      if (respDelay == 0) begin
        memRespValid <= 1'b1;
        memRespData  <= lineMem[pendLine];
      end
    end
    if (memReqValid && memReqReady) begin
      if (memReqWrite) begin
        lineMem[memReqAddr[5:0]] = memReqData;
        wbCount++;
        lastWb = int'(memReqAddr);
      end else begin
        fillCount++;
        wbAtFill  = wbCount;
        pendLine  = int'(memReqAddr[5:0]);
        respDelay = 3;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpuOp(input bit wr, input int line, input int word, input logic [63:0] d,
                       input logic [7:0] be, output logic [63:0] rd, output int cyc);
    @(negedge clk);
    cpuReqValid  = 1'b1;
    cpuReqWrite  = wr;
    cpuReqAddr   = ADDR_W'(line*64 + word*8);
    cpuReqWdata  = d;
    cpuReqByteEn = be;
    cyc = 0;
    #1;
    while (!cpuAck && cyc < 1000) begin
      @(negedge clk);
      #1;
      cyc++;
    end
    rd = cpuRdata;
    @(negedge clk);
    cpuReqValid = 1'b0;
    cpuReqWrite = 1'b0;
  endtask

  task automatic snoop(input int line, output int cyc);
    @(negedge clk);
    snpValid = 1'b1;
    snpAddr  = LADDR_W'(line);
    cyc = 0;
    #1;
    while (!snpAck && cyc < 1000) begin
      @(negedge clk);
      #1;
      cyc++;
    end
    @(negedge clk);
    snpValid = 1'b0;
  endtask

  logic [63:0] exp12, exp20, valY;

  task automatic tReset();
    @(negedge clk);
    chk(!cpuAck && !memReqValid && !invReqValid && !snpAck, "R13 idle outputs in reset",
        {cpuAck, memReqValid, invReqValid, snpAck}, 64'h0);
  endtask

  task automatic tReadMiss();
    logic [63:0] rd; int cyc; int f0 = fillCount, w0 = wbCount;
    cpuOp(1'b0, 1, 2, '0, '0, rd, cyc);
    chk(fillCount - f0 == 1, "R13 first access after reset misses", 64'(fillCount - f0), 64'd1);
    chk(rd == pat(1, 2), "R3 read miss data", rd, pat(1, 2));
    chk(wbCount == w0, "R9 empty way needs no write-back", 64'(wbCount - w0), 64'd0);
  endtask

  task automatic tReadHit();
    logic [63:0] rd; int cyc; int f0 = fillCount;
    cpuOp(1'b0, 1, 2, '0, '0, rd, cyc);
    chk(cyc == 0, "R1 read hit same cycle", 64'(cyc), 64'd0);
    chk(fillCount == f0, "R1 read hit no fetch", 64'(fillCount - f0), 64'd0);
    chk(rd == pat(1, 2), "R1 read hit data", rd, pat(1, 2));
  endtask

  task automatic tWriteShared();
    logic [63:0] rd; int cyc; int i0 = invCount, w0 = wbCount;
    logic [63:0] d = 64'h1111_2222_3333_4444;
    cpuOp(1'b1, 1, 2, d, 8'h0F, rd, cyc);
    exp12 = merge(pat(1, 2), d, 8'h0F);
    chk(invCount - i0 == 1, "R4 one invalidate on shared write", 64'(invCount - i0), 64'd1);
    chk(lastInv == 1, "R4 invalidate line address", 64'(lastInv), 64'd1);
    chk(cyc >= 2, "R4 stalled until acknowledge", 64'(cyc), 64'd2);
    chk(wbCount == w0, "R2 write hit no memory write", 64'(wbCount - w0), 64'd0);
    cpuOp(1'b0, 1, 2, '0, '0, rd, cyc);
    chk(rd == exp12, "R2 only enabled bytes change", rd, exp12);
  endtask

  task automatic tWritePrivate();
    logic [63:0] rd; int cyc; int i0 = invCount;
    logic [63:0] d = 64'hCAFE_F00D_0123_4567;
    cpuOp(1'b1, 1, 5, d, 8'hFF, rd, cyc);
    chk(invCount == i0, "R5 no second invalidate", 64'(invCount - i0), 64'd0);
    chk(cyc == 0, "R5 private write acknowledged at once", 64'(cyc), 64'd0);
    cpuOp(1'b0, 1, 5, '0, '0, rd, cyc);
    chk(rd == d, "R2 full word write", rd, d);
  endtask

  task automatic tWriteMiss();
    logic [63:0] rd; int cyc; int f0 = fillCount, i0 = invCount;
    logic [63:0] d = 64'h7700_0000_0000_0000;
    cpuOp(1'b1, 2, 0, d, 8'h80, rd, cyc);
    exp20 = merge(pat(2, 0), d, 8'h80);
    chk(fillCount - f0 == 1, "R6 write miss refills", 64'(fillCount - f0), 64'd1);
    chk(invCount - i0 == 1, "R6 write miss invalidates", 64'(invCount - i0), 64'd1);
    chk(lastInv == 2, "R6 invalidate address", 64'(lastInv), 64'd2);
    cpuOp(1'b0, 2, 0, '0, '0, rd, cyc);
    chk(rd == exp20, "R6 write applied after refill", rd, exp20);
  endtask

  task automatic tFreeWayFirst();
    logic [63:0] rd; int cyc; int f0 = fillCount, w0 = wbCount;
    cpuOp(1'b0, 5, 1, '0, '0, rd, cyc);
    chk(rd == pat(5, 1), "R3 second way refill data", rd, pat(5, 1));
    chk(wbCount == w0, "R7 no eviction while a way is free", 64'(wbCount - w0), 64'd0);
    cpuOp(1'b0, 1, 2, '0, '0, rd, cyc);
    chk(fillCount - f0 == 1, "R7 earlier line still resident", 64'(fillCount - f0), 64'd1);
    chk(rd == exp12, "R7 resident data", rd, exp12);
  endtask

  task automatic tDirtyVictim();
    logic [63:0] rd; int cyc; int w0;
    valY = 64'h5A5A_A5A5_0F0F_F0F0;
    cpuOp(1'b1, 5, 1, valY, 8'hFF, rd, cyc);
    w0 = wbCount;
    cpuOp(1'b0, 9, 0, '0, '0, rd, cyc);
    chk(wbCount - w0 == 1, "R8 dirty victim written back", 64'(wbCount - w0), 64'd1);
    chk(wbAtFill == wbCount, "R8 write-back before refill", 64'(wbAtFill), 64'(wbCount));
    chk(lastWb == 1 || lastWb == 5, "R8 victim line address", 64'(lastWb), 64'd1);
    if (lastWb == 1) chk(memWord(1, 2) == exp12, "R8 full line data", memWord(1, 2), exp12);
    else             chk(memWord(5, 1) == valY,  "R8 full line data", memWord(5, 1), valY);
    chk(rd == pat(9, 0), "R3 refill after write-back", rd, pat(9, 0));
  endtask

  task automatic tCleanVictim();
    logic [63:0] rd; int cyc; int w0 = wbCount;
    cpuOp(1'b0, 3, 0, '0, '0, rd, cyc);
    cpuOp(1'b0, 7, 0, '0, '0, rd, cyc);
    cpuOp(1'b0, 11, 4, '0, '0, rd, cyc);
    chk(wbCount == w0, "R9 clean victim dropped", 64'(wbCount - w0), 64'd0);
    chk(rd == pat(11, 4), "R9 replacement data", rd, pat(11, 4));
  endtask

  task automatic tSnoopClean();
    logic [63:0] rd; int cyc; int w0, f0;
    cpuOp(1'b0, 6, 3, '0, '0, rd, cyc);
    w0 = wbCount;
    snoop(6, cyc);
    chk(cyc == 0, "R10 clean snoop acknowledged at once", 64'(cyc), 64'd0);
    chk(wbCount == w0, "R10 clean snoop no write", 64'(wbCount - w0), 64'd0);
    f0 = fillCount;
    cpuOp(1'b0, 6, 3, '0, '0, rd, cyc);
    chk(fillCount - f0 == 1, "R10 snooped line gone", 64'(fillCount - f0), 64'd1);
  endtask

  task automatic tSnoopDirty();
    logic [63:0] rd; int cyc; int w0 = wbCount, f0;
    snoop(2, cyc);
    chk(wbCount - w0 == 1, "R11 dirty snoop writes back", 64'(wbCount - w0), 64'd1);
    chk(lastWb == 2, "R11 write-back address", 64'(lastWb), 64'd2);
    chk(memWord(2, 0) == exp20, "R11 written-back data", memWord(2, 0), exp20);
    f0 = fillCount;
    cpuOp(1'b0, 2, 0, '0, '0, rd, cyc);
    chk(fillCount - f0 == 1, "R11 line invalidated", 64'(fillCount - f0), 64'd1);
    chk(rd == exp20, "R11 data recovered from memory", rd, exp20);
  endtask

  task automatic tSnoopMiss();
    logic [63:0] rd; int cyc; int w0 = wbCount, f0;
    snoop(40, cyc);
    chk(cyc == 0 && wbCount == w0, "R12 snoop miss acknowledged quietly", 64'(wbCount - w0), 64'd0);
    f0 = fillCount;
    cpuOp(1'b0, 6, 3, '0, '0, rd, cyc);
    chk(fillCount == f0, "R12 resident line kept", 64'(fillCount - f0), 64'd0);
    chk(rd == pat(6, 3), "R12 resident data", rd, pat(6, 3));
  endtask

  initial begin
    for (int l = 0; l < 64; l++)
      for (int w = 0; w < 8; w++) lineMem[l][w*64 +: 64] = pat(l, w);
    repeat (2) @(posedge clk);
    tReset();
    @(negedge clk);
    rstN = 1'b1;
    tReadMiss();
    tReadHit();
    tWriteShared();
    tWritePrivate();
    tWriteMiss();
    tFreeWayFirst();
    tDirtyVictim();
    tCleanVictim();
    tSnoopClean();
    tSnoopDirty();
    tSnoopMiss();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule